// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns a 24-bit virtual address into a 24-bit physical address for a memory made of 256-byte pages. The upper 16 bits of the virtual address are the page number and the lower 8 bits are the byte offset. The unit first searches a small, fully associative buffer of recent page-to-frame pairs. When the page is found there, the frame is returned one cycle after the request is accepted.

When the page is not in the buffer, the unit compares the page number with a limit register. A page number above the limit ends the request as a bounds fault, with no memory traffic. A page number within the limit causes one read of the page-map table at the address base register plus page number. The returned 16-bit frame number completes the translation and is also written into the buffer.

The base and limit values are loaded together through a load port when the process changes. The same load clears every buffer entry. The unit handles one translation at a time.

Top module: `paging_xlate_unit`

## Requirements
- R1: The physical address is the 16-bit frame number in bits 23:8 followed by the 8-bit offset copied unchanged from virtual address bits 7:0. A faulted response carries a physical address of zero.
- R2: On a buffer hit, `resp_valid_o` is high in the cycle after the accepting edge, with `resp_fault_o` low and no table read issued.
- R3: On an in-bounds miss, exactly one table read is issued at address `base + page` (24-bit, wrapping), and the response carries the frame read from that address.
- R4: On a miss whose page number is above the limit, the response comes in the cycle after acceptance with `resp_fault_o` high and no table read. A page number equal to the limit is in bounds.
- R5: After a table walk completes, a later request for the same page hits in the buffer until that entry is evicted or cleared.
- R6: A fill goes to the lowest-index invalid entry. When all 8 entries are valid, it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset or a load and advances by one, wrapping, on each such replacement.
- R7: A pulse on `ld_en_i` loads base and limit together and invalidates every buffer entry. The next access to any page then misses.
- R8: `req_ready_o` is high only when no translation is in progress. It drops after an accepted request and stays low through the response cycle.
- R9: `mem_req_o` and `mem_addr_o` stay stable until `mem_ready_i` accepts the read. The frame is taken in the cycle `mem_rvalid_i` is high, and that is also the response cycle.
- R10: After reset, `req_ready_o` is high, `resp_valid_o` and `mem_req_o` are low, and the buffer is empty.
- R11: If several buffer entries match, the lowest-index match is used. Such duplicates are never created by fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Unit idle, request accepted |
| req_vaddr_i | input | 24 | Virtual address |
| resp_valid_o | output | 1 | Response pulse |
| resp_paddr_o | output | 24 | Physical address |
| resp_fault_o | output | 1 | Page number above limit |
| ld_en_i | input | 1 | Load base and limit, clear buffer |
| ld_base_i | input | 24 | Table base address |
| ld_limit_i | input | 16 | Highest valid page number |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 24 | Table entry address |
| mem_ready_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Frame number read |

## Verification
The bench builds the unit with its default parameters: 8 buffer entries, 16-bit page and frame numbers, and an 8-bit offset. With eight entries, a sweep of twelve pages fills every invalid slot and then drives the round-robin pointer through several replacements. A bench model of the buffer predicts each hit, miss and victim. Table contents are an arithmetic function of the entry address, so a wrapping base and the extreme limits 0 and 0xFFFF can both be checked. Memory accept and return delays vary with each access, so the walk is seen under several stall patterns.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REQ,
    ST_WAIT
  } xlate_st_e;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int N     = 8,
  parameter int VPN_W = 16,
  parameter int PFN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld_q;
  logic [VPN_W-1:0] tag_q [N];
  logic [PFN_W-1:0] pfn_q [N];
  logic [IDX_W-1:0] rr_q;
  logic [N-1:0]     match;
  logic [IDX_W-1:0] free_idx, vict;
  logic             all_vld;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn_i);
  end

  // lowest index wins: later loop iterations overwrite higher ones
  always_comb begin
    hit_o     = 1'b0;
    hit_pfn_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_pfn_o = pfn_q[i];
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign all_vld = &vld_q;
  assign vict    = all_vld ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (fill_i) begin
      vld_q[vict] <= 1'b1;
      if (all_vld) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !flush_i) begin
      tag_q[vict] <= fill_vpn_i;
      pfn_q[vict] <= fill_pfn_i;
    end
  end

  p_one_match_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  p_flush_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_q == '0) && !hit_o);

  p_fill_hits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i && (lk_vpn_i == fill_vpn_i)) |=>
      ($stable(lk_vpn_i) |-> hit_o));
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int VPN_W = 16,
  parameter int PFN_W = 16,
  parameter int OFS_W = 8,
  parameter int TA_W  = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [VPN_W+OFS_W-1:0] req_vaddr_i,
  output logic                   resp_valid_o,
  output logic [PFN_W+OFS_W-1:0] resp_paddr_o,
  output logic                   resp_fault_o,
  input  logic                   ld_en_i,
  input  logic [TA_W-1:0]        ld_base_i,
  input  logic [VPN_W-1:0]       ld_limit_i,
  output logic [VPN_W-1:0]       lk_vpn_o,
  input  logic                   tlb_hit_i,
  input  logic [PFN_W-1:0]       tlb_pfn_i,
  output logic                   flush_o,
  output logic                   fill_o,
  output logic [VPN_W-1:0]       fill_vpn_o,
  output logic [PFN_W-1:0]       fill_pfn_o,
  output logic                   mem_req_o,
  output logic [TA_W-1:0]        mem_addr_o,
  input  logic                   mem_ready_i,
  input  logic                   mem_rvalid_i,
  input  logic [PFN_W-1:0]       mem_rdata_i
);
  xlate_st_e        st_q, st_d;
  logic [VPN_W-1:0] vpn_q, limit_q;
  logic [OFS_W-1:0] ofs_q;
  logic [TA_W-1:0]  base_q;
  logic             in_bnd, look, walk_done;
  logic [PFN_W-1:0] pfn_sel;

  assign in_bnd    = vpn_q <= limit_q;
  assign look      = st_q == ST_LOOK;
  assign walk_done = (st_q == ST_WAIT) && mem_rvalid_i;

  assign req_ready_o  = st_q == ST_IDLE;
  assign lk_vpn_o     = vpn_q;
  assign mem_req_o    = st_q == ST_REQ;
  assign mem_addr_o   = base_q + TA_W'(vpn_q);
  assign resp_fault_o = look && !tlb_hit_i && !in_bnd;
  assign resp_valid_o = (look && (tlb_hit_i || !in_bnd)) || walk_done;
  assign pfn_sel      = walk_done ? mem_rdata_i : tlb_pfn_i;
  assign resp_paddr_o = resp_fault_o ? '0 : {pfn_sel, ofs_q};
  assign flush_o      = ld_en_i;
  assign fill_o       = walk_done;
  assign fill_vpn_o   = vpn_q;
  assign fill_pfn_o   = mem_rdata_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_LOOK;
      ST_LOOK: st_d = (tlb_hit_i || !in_bnd) ? ST_IDLE : ST_REQ;
      ST_REQ:  if (mem_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vpn_q   <= '0;
      ofs_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      st_q <= st_d;
      if (req_valid_i && req_ready_o) begin
        vpn_q <= req_vaddr_i[VPN_W+OFS_W-1:OFS_W];
        ofs_q <= req_vaddr_i[OFS_W-1:0];
      end
      if (ld_en_i) begin
        base_q  <= ld_base_i;
        limit_q <= ld_limit_i;
      end
    end
  end

  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_hit_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (tlb_hit_i |-> (resp_valid_o && !resp_fault_o)));

  p_fault_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |=> !mem_req_o);

  p_req_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && !ld_en_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: rtl/paging_xlate_unit.sv
module paging_xlate_unit #(
  parameter int OFS_W = 8,
  parameter int VPN_W = 16,
  parameter int PFN_W = 16,
  parameter int TLB_N = 8,
  parameter int TA_W  = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [VPN_W+OFS_W-1:0] req_vaddr_i,
  output logic                   resp_valid_o,
  output logic [PFN_W+OFS_W-1:0] resp_paddr_o,
  output logic                   resp_fault_o,
  input  logic                   ld_en_i,
  input  logic [TA_W-1:0]        ld_base_i,
  input  logic [VPN_W-1:0]       ld_limit_i,
  output logic                   mem_req_o,
  output logic [TA_W-1:0]        mem_addr_o,
  input  logic                   mem_ready_i,
  input  logic                   mem_rvalid_i,
  input  logic [PFN_W-1:0]       mem_rdata_i
);
  logic [VPN_W-1:0] lk_vpn, fill_vpn;
  logic [PFN_W-1:0] tlb_pfn, fill_pfn;
  logic             tlb_hit, flush, fill;

  xlate_ctrl #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .OFS_W(OFS_W), .TA_W(TA_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_vaddr_i,
    .resp_valid_o, .resp_paddr_o, .resp_fault_o,
    .ld_en_i, .ld_base_i, .ld_limit_i,
    .lk_vpn_o   (lk_vpn),
    .tlb_hit_i  (tlb_hit),
    .tlb_pfn_i  (tlb_pfn),
    .flush_o    (flush),
    .fill_o     (fill),
    .fill_vpn_o (fill_vpn),
    .fill_pfn_o (fill_pfn),
    .mem_req_o, .mem_addr_o, .mem_ready_i, .mem_rvalid_i, .mem_rdata_i
  );

  xlate_tlb #(
    .N(TLB_N), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_tlb (
    .clk_i, .rst_ni,
    .flush_i    (flush),
    .lk_vpn_i   (lk_vpn),
    .hit_o      (tlb_hit),
    .hit_pfn_o  (tlb_pfn),
    .fill_i     (fill),
    .fill_vpn_i (fill_vpn),
    .fill_pfn_i (fill_pfn)
  );
endmodule

// File: tb/sim_paging_xlate_unit.sv
module sim_paging_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [23:0] req_vaddr_i = '0;
  logic        resp_valid_o;
  logic [23:0] resp_paddr_o;
  logic        resp_fault_o;
  logic        ld_en_i = 1'b0;
  logic [23:0] ld_base_i = '0;
  logic [15:0] ld_limit_i = '0;
  logic        mem_req_o;
  logic [23:0] mem_addr_o;
  logic        mem_ready_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  paging_xlate_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i, .req_ready_o, .req_vaddr_i,
    .resp_valid_o, .resp_paddr_o, .resp_fault_o,
    .ld_en_i, .ld_base_i, .ld_limit_i,
    .mem_req_o, .mem_addr_o, .mem_ready_i, .mem_rvalid_i, .mem_rdata_i
  );

  function automatic logic [15:0] tab(input logic [23:0] a);
    return 16'((a * 37 + 5) ^ (a >> 7));
  endfunction

  // memory model: varying accept and return delays
  int mem_cnt = 0, gcnt = 0, lcnt = 0;
  bit pend = 0;
  logic [23:0] last_addr = '0;
  always @(negedge clk) begin
    mem_ready_i  = 1'b0;
    mem_rvalid_i = 1'b0;
    if (pend) begin
      if (lcnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = tab(last_addr);
        pend = 0;
        gcnt = mem_cnt % 3;
      end else lcnt--;
    end else if (mem_req_o) begin
      if (gcnt == 0) begin
        mem_ready_i = 1'b1;
        last_addr = mem_addr_o;
        pend = 1;
        lcnt = mem_cnt % 4;
        mem_cnt++;
      end else gcnt--;
    end
  end

  // buffer reference model
  bit          m_vld [8];
  logic [15:0] m_vpn [8];
  logic [15:0] m_pfn [8];
  int          m_rr = 0;
  logic [23:0] cur_base = '0;
  logic [15:0] cur_lim = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] b, input logic [15:0] l);
    @(negedge clk);
    ld_en_i = 1'b1; ld_base_i = b; ld_limit_i = l;
    @(negedge clk);
    ld_en_i = 1'b0;
    cur_base = b; cur_lim = l; m_rr = 0;
    for (int i = 0; i < 8; i++) m_vld[i] = 0;
  endtask

  task automatic xl(input logic [23:0] va);
    logic [15:0] vpn, epfn;
    logic [23:0] ta, epa;
    int hi, n0, cyc, slot;
    bit flt;
    vpn = va[23:8];
    hi = -1;
    for (int i = 7; i >= 0; i--) if (m_vld[i] && m_vpn[i] == vpn) hi = i;
    flt  = (hi < 0) && (vpn > cur_lim);
    ta   = cur_base + {8'h00, vpn};
    epfn = (hi >= 0) ? m_pfn[hi] : tab(ta);
    epa  = flt ? 24'h0 : {epfn, va[7:0]};
    n0   = mem_cnt;
    @(negedge clk);
    req_vaddr_i = va; req_valid_i = 1'b1;
    #2 chk(req_ready_o, "R8", "ready when idle", 32'(req_ready_o), 1);
    @(negedge clk);
    req_valid_i = 1'b0;
    #2 cyc = 1;
    while (!resp_valid_o && cyc < 100) begin
      @(negedge clk); #2 cyc++;
    end
    chk(resp_valid_o, "R8", "response seen", 32'(resp_valid_o), 1);
    chk(!req_ready_o, "R8", "ready low in response cycle", 32'(req_ready_o), 0);
    chk(resp_paddr_o == epa, flt ? "R1" : (hi >= 0 ? "R1" : "R3"), "paddr", 32'(resp_paddr_o), 32'(epa));
    chk(resp_fault_o == flt, "R4", "fault flag", 32'(resp_fault_o), 32'(flt));
    if (hi >= 0) begin
      chk(cyc == 1, "R2", "hit latency", 32'(cyc), 1);
      chk(mem_cnt == n0, "R2", "hit reads", 32'(mem_cnt - n0), 0);
    end else if (flt) begin
      chk(cyc == 1, "R4", "fault latency", 32'(cyc), 1);
      chk(mem_cnt == n0, "R4", "fault reads", 32'(mem_cnt - n0), 0);
    end else begin
      chk(cyc >= 3, "R5", "miss latency (entry should be absent)", 32'(cyc), 3);
      chk(mem_cnt == n0 + 1, "R3", "miss reads", 32'(mem_cnt - n0), 1);
      chk(last_addr == ta, "R3", "table addr", 32'(last_addr), 32'(ta));
      slot = -1;
      for (int i = 7; i >= 0; i--) if (!m_vld[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % 8;
      end
      m_vld[slot] = 1; m_vpn[slot] = vpn; m_pfn[slot] = epfn;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_vld[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; end
    #20 rst_n = 1'b1;
    @(negedge clk); #2;
    chk(req_ready_o, "R10", "reset ready", 32'(req_ready_o), 1);
    chk(!resp_valid_o, "R10", "reset resp", 32'(resp_valid_o), 0);
    chk(!mem_req_o, "R10", "reset mem req", 32'(mem_req_o), 0);

    // R4/R3: limit 5, sweep past it; vpn 5 equals limit and is in bounds
    load(24'h001000, 16'd5);
    for (int v = 0; v < 8; v++) xl({16'(v), 8'(v * 29 + 3)});
    // R5/R2: revisit, all hits; faults stay faults
    for (int v = 0; v < 8; v++) xl({16'(v), 8'(255 - v)});

    // R7: new process, wrapping base; R6: twelve pages overflow eight slots
    load(24'hFFFFF8, 16'd20);
    for (int v = 0; v < 12; v++) xl({16'(v), 8'(v * 7)});
    for (int v = 4; v < 12; v++) xl({16'(v), 8'hA5});
    for (int v = 0; v < 4; v++) xl({16'(v), 8'h3C});
    for (int v = 4; v < 12; v++) xl({16'(v), 8'h11});
    for (int v = 16; v < 22; v++) xl({16'(v), 8'(v)});

    // limit extremes
    load(24'h000200, 16'hFFFF);
    xl({16'hFFFF, 8'h7A});
    xl({16'h8000, 8'h01});
    xl({16'hFFFF, 8'h00});
    load(24'h000003, 16'h0000);
    xl({16'h0000, 8'hEE});
    xl({16'h0001, 8'hEE});
    xl({16'hFFFF, 8'h00});
    xl({16'h0000, 8'h12});

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule